// File: doc/BRIEF.md
# Transponder ID Frame Checker

This block watches a stream of already-decoded bits from a read-only identification transponder. Each accepted bit arrives with a one-cycle valid strobe. The block looks for the frame start, which is nine ones in a row. It then collects ten rows of four data bits, each row followed by a row parity bit. After the rows come four column parity bits and a stop bit. Every parity bit and the stop bit are checked as soon as they arrive.

When a frame passes every check, the 40 data bits are loaded into the ID output and a one-cycle valid pulse is raised. The version or customer field sits in the top eight bits of the ID. The 32-bit number sits in the low 32 bits. Any failed check drops the frame and pulses an error output. The header search then restarts at the failing bit.

Tags send their frames back to back, so the checker is always hunting or collecting and never needs an idle gap. A mode input picks one of two parity rules. The standard rule makes every parity bit even. The alternate rule makes the first two row parities odd.

Top module: `tag_frame_checker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `id_out` is 0 and `id_vld` and `frame_err` are both 0.
- R2: The block acts only on cycles where `bit_vld` is 1. On a cycle with `bit_vld` low, `bit_in` has no effect: it neither adds to nor clears the header count, and it is not taken into a frame.
- R3: A frame begins after nine accepted 1 bits in a row. The next 55 accepted bits are the payload, in this order: ten rows of five bits, then four column parity bits, then the stop bit. In each row the first four bits are data and the fifth is the row parity. With `psk_mode` = 0, the five bits of every row must hold an even number of ones.
- R4: With `psk_mode` = 1, rows 0 and 1 (the first two rows received) must hold an odd number of ones, and rows 2 to 9 an even number.
- R5: Column parity bit c (c = 0..3, in the order received) must make the ten data bits in position c of each row, plus itself, hold an even number of ones. This rule is the same in both modes.
- R6: The stop bit (payload bit 55) must be 0.
- R7: When the stop bit of a frame is accepted and every check has passed, `id_vld` is 1 for exactly one cycle, the cycle after the stop bit is accepted. In that same cycle `id_out` holds the 40 data bits in the order received: the first data bit is in bit 39 and the last is in bit 0.
- R8: `id_out` changes only in a cycle where `id_vld` is 1. A failed frame leaves `id_out` unchanged.
- R9: After a good stop bit the header count starts again from zero, so a header that follows at once is recognised.
- R10: A failed check pulses `frame_err` for one cycle, the cycle after the failing bit is accepted, and drops the frame. The failing bit itself is the first bit of the new header search: if it is 1, it counts as the first of the nine ones.
- R11: `id_vld` and `frame_err` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Decoded data bit |
| bit_vld | input | 1 | Marks a cycle whose `bit_in` is accepted |
| psk_mode | input | 1 | 0: all parities even; 1: first two row parities odd |
| id_out | output | 40 | Last good ID, first-received data bit in bit 39 |
| id_vld | output | 1 | One-cycle pulse when a good frame ends |
| frame_err | output | 1 | One-cycle pulse when a check fails |

## Verification
The bench goes after several corner cases, and each one shows up in a clear way if the design gets it wrong:
- Strobe gaps while `bit_in` is held at 1. A checker that counted these idle cycles would close the header early and misalign the whole frame.
- A bad stop bit of 1 followed by only eight more ones. The frame after it is lost unless the failing bit counts as the first header one.
- Back-to-back frames with no gap between them.
- A standard frame read in the alternate mode. It must fail at row 0, and a design with the wrong parity rule accepts it.
- Random streams with single flipped bits, junk between frames and strobe gaps. These are compared cycle by cycle against a bench model, so an early or late error pulse, or a stray ID update, shows up at once.

// File: rtl/tag_frame_checker.sv
module tag_frame_checker #(
  parameter int ROWS     = 10,
  parameter int COLS     = 4,
  parameter int HDR_LEN  = 9,
  parameter int ODD_ROWS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_in,
  input  logic                 bit_vld,
  input  logic                 psk_mode,
  output logic [ROWS*COLS-1:0] id_out,
  output logic                 id_vld,
  output logic                 frame_err
);
  localparam int ID_W  = ROWS * COLS;
  localparam int ROW_W = $clog2(ROWS + 1);
  localparam int COL_W = $clog2(COLS + 1);
  localparam int HDR_W = $clog2(HDR_LEN + 1);

  logic             active_q;
  logic [HDR_W-1:0] ones_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             row_par_q;
  logic [COLS-1:0]  col_par_q;
  logic [ID_W-1:0]  sr_q;

  wire             in_rows  = row_q < ROW_W'(ROWS);
  wire             data_pos = col_q < COL_W'(COLS);
  wire             odd_row  = psk_mode && (row_q < ROW_W'(ODD_ROWS));
  wire [COLS-1:0]  col_hot  = COLS'(1) << col_q;

  wire row_bad  = in_rows && !data_pos && ((row_par_q ^ bit_in) != odd_row);
  wire colp_bad = !in_rows && data_pos && ((|(col_par_q & col_hot)) ^ bit_in);
  wire stop_pos = !in_rows && !data_pos;

  wire take     = bit_vld && active_q;
  wire fail     = take && (row_bad || colp_bad || (stop_pos && bit_in));
  wire pass     = take && stop_pos && !bit_in;
  wire hdr_done = bit_vld && !active_q && bit_in && (ones_q == HDR_W'(HDR_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      ones_q    <= '0;
      row_q     <= '0;
      col_q     <= '0;
      row_par_q <= 1'b0;
      col_par_q <= '0;
      sr_q      <= '0;
      id_out    <= '0;
      id_vld    <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      id_vld    <= pass;
      frame_err <= fail;
      if (pass) id_out <= sr_q;
      if (bit_vld) begin
        if (!active_q) begin
          if (hdr_done) begin
            active_q  <= 1'b1;
            ones_q    <= '0;
            row_q     <= '0;
            col_q     <= '0;
            row_par_q <= 1'b0;
            col_par_q <= '0;
          end else begin
            ones_q <= bit_in ? ones_q + HDR_W'(1) : '0;
          end
        end else if (fail) begin
          active_q <= 1'b0;
          ones_q   <= bit_in ? HDR_W'(1) : '0;
        end else if (pass) begin
          active_q <= 1'b0;
          ones_q   <= '0;
        end else if (data_pos) begin
          col_q <= col_q + COL_W'(1);
          if (in_rows) begin
            sr_q      <= {sr_q[ID_W-2:0], bit_in};
            row_par_q <= row_par_q ^ bit_in;
            col_par_q <= col_par_q ^ (col_hot & {COLS{bit_in}});
          end
        end else begin
          col_q     <= '0;
          row_q     <= row_q + ROW_W'(1);
          row_par_q <= 1'b0;
        end
      end
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_vld && frame_err)); // R11
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !id_vld |-> $stable(id_out)); // R8
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    id_vld |=> !id_vld); // R7
  AST_ERR_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(bit_vld)); // R2
  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    id_vld |-> ($past(bit_vld) && !$past(bit_in))); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err || $past(bit_vld)); // R10
endmodule

// File: tb/tag_frame_checker_test.sv
`timescale 1ns/1ps
module tag_frame_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_in = 1'b0;
  logic        bit_vld = 1'b0;
  logic        psk_mode = 1'b0;
  logic [39:0] id_out;
  logic        id_vld;
  logic        frame_err;

  tag_frame_checker uut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .psk_mode(psk_mode), .id_out(id_out), .id_vld(id_vld), .frame_err(frame_err)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int n_vld = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  bit          m_in = 1'b0;
  int          m_ones = 0;
  int          m_n = 0;
  bit          m_pay [0:54];
  logic [39:0] m_id = '0;
  bit          m_vld = 1'b0;
  bit          m_err = 1'b0;

  function automatic bit pos_ok(input int n, input bit psk);
    int s;
    if (n < 50 && n % 5 == 4) begin
      s = 0;
      for (int k = n - 4; k <= n; k++) s += m_pay[k];
      return (s % 2) == ((psk && n < 10) ? 1 : 0);
    end
    if (n >= 50 && n < 54) begin
      s = m_pay[n];
      for (int r = 0; r < 10; r++) s += m_pay[r*5 + (n-50)];
      return (s % 2) == 0;
    end
    if (n == 54) return m_pay[54] == 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [39:0] gather();
    logic [39:0] v;
    for (int r = 0; r < 10; r++)
      for (int c = 0; c < 4; c++) v[39 - (r*4 + c)] = m_pay[r*5 + c];
    return v;
  endfunction

  task automatic model_bit(input bit b, input bit psk);
    m_vld = 1'b0;
    m_err = 1'b0;
    if (!m_in) begin
      if (b) begin
        if (m_ones == 8) begin m_in = 1'b1; m_n = 0; m_ones = 0; end
        else m_ones++;
      end else m_ones = 0;
    end else begin
      m_pay[m_n] = b;
      if (!pos_ok(m_n, psk)) begin
        m_err = 1'b1; m_in = 1'b0; m_ones = b ? 1 : 0;
      end else if (m_n == 54) begin
        m_vld = 1'b1; m_id = gather(); m_in = 1'b0; m_ones = 0;
      end else m_n++;
    end
  endtask

  function automatic logic [63:0] build(input logic [39:0] id, input bit psk);
    logic [63:0] f;
    logic [3:0]  cp;
    int i;
    f = '0; cp = '0; i = 0;
    for (int h = 0; h < 9; h++) begin f[63-i] = 1'b1; i++; end
    for (int r = 0; r < 10; r++) begin
      logic p;
      p = psk && r < 2;
      for (int c = 0; c < 4; c++) begin
        f[63-i] = id[39 - (r*4 + c)];
        p ^= id[39 - (r*4 + c)];
        cp[c] ^= id[39 - (r*4 + c)];
        i++;
      end
      f[63-i] = p; i++;
    end
    for (int c = 0; c < 4; c++) begin f[63-i] = cp[c]; i++; end
    f[63-i] = 1'b0;
    return f;
  endfunction

  task automatic send_bit(input bit b);
    bit_in = b; bit_vld = 1'b1;
    model_bit(b, psk_mode);
    @(negedge clk);
    chk(id_vld === m_vld, "R7 id_vld", id_vld, m_vld);
    chk(frame_err === m_err, "R10 frame_err", frame_err, m_err);
    chk(id_out === m_id, "R8 id_out", id_out, m_id);
    chk(!(id_vld && frame_err), "R11 exclusive", {id_vld, frame_err}, 0);
    if (id_vld) n_vld++;
    if (frame_err) n_err++;
    bit_vld = 1'b0;
  endtask

  task automatic idle(input bit b);
    bit_in = b; bit_vld = 1'b0;
    @(negedge clk);
    chk(!id_vld && !frame_err, "R2 idle pulses", {id_vld, frame_err}, 0);
    chk(id_out === m_id, "R2 idle id", id_out, m_id);
  endtask

  task automatic send_range(input logic [63:0] f, input int from, input int to);
    for (int i = from; i <= to; i++) send_bit(f[63-i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] f;
    logic [39:0] id;
    void'($urandom(32'd4102));
    repeat (3) @(negedge clk);
    chk(id_out === '0 && !id_vld && !frame_err, "R1 in reset", {id_vld, frame_err, id_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(id_out === '0 && !id_vld && !frame_err, "R1 after reset", {id_vld, frame_err, id_out}, 0);

    // R7: single good standard frame
    id = 40'hA5_1234_5678; n_vld = 0;
    send_range(build(id, 1'b0), 0, 63);
    chk(n_vld == 1 && id_out == id, "R7 good frame", id_out, id);

    // R9: back-to-back frames
    n_vld = 0; n_err = 0;
    send_range(build(40'h3C_DEAD_BEEF, 1'b0), 0, 63);
    send_range(build(40'h01_0000_0001, 1'b0), 0, 63);
    chk(n_vld == 2 && n_err == 0, "R9 back-to-back count", n_vld, 2);
    chk(id_out == 40'h01_0000_0001, "R9 second id", id_out, 40'h01_0000_0001);

    // R4: alternate mode frame, then a standard frame read in alternate mode
    psk_mode = 1'b1; n_vld = 0; n_err = 0;
    send_range(build(40'h77_CAFE_F00D, 1'b1), 0, 63);
    chk(n_vld == 1 && id_out == 40'h77_CAFE_F00D, "R4 odd-row frame", id_out, 40'h77_CAFE_F00D);
    n_vld = 0; n_err = 0;
    send_range(build(40'h12_3456_789A, 1'b0), 0, 63);
    chk(n_vld == 0 && n_err >= 1, "R4 even rows rejected", n_err, 1);
    chk(id_out == 40'h77_CAFE_F00D, "R8 id held after reject", id_out, 40'h77_CAFE_F00D);
    psk_mode = 1'b0;
    repeat (10) send_bit(1'b0);

    // R3: row parity flip at row 3
    f = build(40'hFF_0F0F_F0F0, 1'b0); f[63-(9+3*5+4)] ^= 1'b1;
    n_vld = 0; n_err = 0;
    send_range(f, 0, 63);
    chk(n_vld == 0 && n_err >= 1, "R3 row parity error", n_err, 1);
    repeat (10) send_bit(1'b0);

    // R5: column parity flip
    f = build(40'h5A_5A5A_5A5A, 1'b0); f[63-(9+50+2)] ^= 1'b1;
    n_vld = 0; n_err = 0;
    send_range(f, 0, 63);
    chk(n_vld == 0 && n_err == 1, "R5 column parity error", n_err, 1);
    repeat (10) send_bit(1'b0);

    // R6 + R10: bad stop bit 1 counts as first header one
    f = build(40'h00_0000_0000, 1'b0); f[0] = 1'b1;
    n_vld = 0; n_err = 0;
    send_range(f, 0, 63);
    chk(n_err == 1 && n_vld == 0, "R6 stop bit one rejected", n_err, 1);
    send_range(build(40'h9E_8765_4321, 1'b0), 1, 63);
    chk(n_vld == 1 && id_out == 40'h9E_8765_4321, "R10 resync from failing bit", id_out, 40'h9E_8765_4321);

    // R2: idle ones must not advance the header count
    f = build(40'hC3_1111_2222, 1'b0); n_vld = 0; n_err = 0;
    send_range(f, 0, 7);
    repeat (5) idle(1'b1);
    send_range(f, 8, 63);
    chk(n_vld == 1 && n_err == 0 && id_out == 40'hC3_1111_2222, "R2 strobe gaps ignored", id_out, 40'hC3_1111_2222);

    // random mix
    for (int k = 0; k < 250; k++) begin
      psk_mode = $urandom_range(0, 3) == 0;
      id = {$urandom(), $urandom()};
      f = build(id, psk_mode);
      if ($urandom_range(0, 9) < 3) f[$urandom_range(0, 54)] ^= 1'b1;
      for (int i = 0; i < 64; i++) begin
        send_bit(f[63-i]);
        if ($urandom_range(0, 9) == 0) idle($urandom_range(0, 1) == 1);
      end
      repeat ($urandom_range(0, 3)) send_bit($urandom_range(0, 1) == 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule